// File: doc/BRIEF.md
# Receive FIFO Line Status Unit

This unit sits between a serial receiver and the CPU of an asynchronous serial port. The receiver pushes each finished character into a small FIFO. Each character carries three error tags: a parity mismatch, a missing stop bit, and a held-low break. The CPU pops characters through a data read strobe. The unit also builds an 8-bit line status word from the FIFO state, the error tags and the transmit side. The transmit side is reported through the transmit FIFO level and a busy flag from the shift register.

An error tag is shown in the status word only while its character is at the FIFO head. A status read hides the tags of the current head. A sticky summary bit reports that an errored entry is still somewhere in the FIFO. This bit stays set until a status read happens while no tagged entry remains.

A mode input selects between a deep FIFO and a single holding register. In holding mode the summary bit reads 0. The holding-empty flag then follows explicit load and write strobes instead of the transmit FIFO level.

Top module: `rx_line_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 while at least one character is stored and drops after the last one is read. `rd_data` always shows the character at the head.
- R2: With `fifo_en`=1, characters are returned in arrival order and up to DEPTH are held. With `fifo_en`=0, only one character is held.
- R3: A push while full sets status bit 1 (overrun), drops the new character and keeps the stored ones. A status read clears bit 1.
- R4: Status bits 2, 3 and 4 show the parity, framing and break tags of the head character. They read 0 after a status read until the head changes. They read 0 when the FIFO is empty.
- R5: With `fifo_en`=1, status bit 7 is set by an accepted push whose tags are not all zero. It is cleared only by a status read made while no tagged character is stored. With `fifo_en`=0 it reads 0.
- R6: With `fifo_en`=1, status bit 5 (holding empty) is 1 exactly when `tx_level` is 0.
- R7: With `fifo_en`=0, bit 5 is set by `thr_load` and cleared by `thr_wr`, and `thr_wr` wins when both are high. It is 1 after reset.
- R8: Status bit 6 (transmitter empty) is 1 only when bit 5 is 1 and `tsr_busy` is 0.
- R9: `rls_irq` is 1 whenever any of status bits 1 to 4 is 1.
- R10: After reset the status word is 8'h60 and `rls_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects the deep FIFO, 0 selects the single holding register |
| rx_push | input | 1 | Receiver offers a finished character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag of the pushed character |
| rx_ferr | input | 1 | Framing error tag of the pushed character |
| rx_brk | input | 1 | Break tag of the pushed character |
| data_rd | input | 1 | CPU read of the data register, pops the head |
| lsr_rd | input | 1 | CPU read of the status word |
| thr_wr | input | 1 | CPU write of the transmit holding register (holding mode) |
| thr_load | input | 1 | Holding register moved into the shift register (holding mode) |
| tx_level | input | TXW | Transmit FIFO occupancy |
| tsr_busy | input | 1 | Shift register holds a character |
| rd_data | output | 8 | Character at the FIFO head |
| lsr | output | 8 | Line status word |
| rls_irq | output | 1 | Receiver line status interrupt request |

## Verification
The FIFO-mode table covers several input patterns:
- A clean character followed by a framing-tagged one. This shows that a tag stays hidden until its character reaches the head.
- A status read made while a tagged entry is still stored. This separates hiding the head's tags from clearing the summary bit.
- Break and parity characters back to back. This confirms each head shows only its own tag.
- A fill past DEPTH. This confirms that overrun drops the extra character without disturbing order.

Directed steps then cover holding mode, where the second push must overrun and the summary bit must stay 0. They also cover the two sources of the holding-empty flag and the effect of shift-register busy.

// File: rtl/rx_line_status.sv
module rx_line_status #(
  parameter int DEPTH = 16,
  parameter int TXW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fifo_en,
  input  logic           rx_push,
  input  logic [7:0]     rx_data,
  input  logic           rx_perr,
  input  logic           rx_ferr,
  input  logic           rx_brk,
  input  logic           data_rd,
  input  logic           lsr_rd,
  input  logic           thr_wr,
  input  logic           thr_load,
  input  logic [TXW-1:0] tx_level,
  input  logic           tsr_busy,
  output logic [7:0]     rd_data,
  output logic [7:0]     lsr,
  output logic           rls_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, err_cnt;
  logic          seen, ovr, err_sum, thre_q;

  wire        empty   = (count == '0);
  wire        full    = fifo_en ? (count == CW'(DEPTH)) : !empty;
  wire [2:0]  in_tag  = {rx_brk, rx_ferr, rx_perr};
  wire        push_ok = rx_push && !full;
  wire        pop     = data_rd && !empty;
  wire [10:0] head    = mem[rptr];
  wire        head_err = |head[10:8];
  wire [2:0]  hd_tag  = (empty || seen) ? 3'b000 : head[10:8];
  wire        thre    = fifo_en ? (tx_level == '0) : thre_q;

  assign rd_data = head[7:0];
  assign lsr     = {fifo_en & err_sum, thre & !tsr_busy, thre, hd_tag, ovr, !empty};
  assign rls_irq = |lsr[4:1];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= {in_tag, rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      err_cnt <= '0;
      seen    <= 1'b0;
      ovr     <= 1'b0;
      err_sum <= 1'b0;
      thre_q  <= 1'b1;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)     rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count   <= count + CW'(push_ok) - CW'(pop);
      err_cnt <= err_cnt + CW'(push_ok && (|in_tag)) - CW'(pop && head_err);

      if (pop)                  seen <= 1'b0;
      else if (lsr_rd && !empty) seen <= 1'b1;

      if (rx_push && full) ovr <= 1'b1;
      else if (lsr_rd)     ovr <= 1'b0;

      if (!fifo_en)                     err_sum <= 1'b0;
      else if (push_ok && (|in_tag))    err_sum <= 1'b1;
      else if (lsr_rd && err_cnt == '0) err_sum <= 1'b0;

      if (thr_wr)        thre_q <= 1'b0;
      else if (thr_load) thre_q <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && full) |=> lsr[1]); // R3
  AST_FULL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && full && !data_rd) |=> $stable(count)); // R3
  AST_DR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && count == CW'(1) && !rx_push) |=> !lsr[0]); // R1
  AST_SUM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && push_ok && (|in_tag)) |=> (lsr[7] || !fifo_en)); // R5
  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[7] && !lsr_rd && fifo_en) |=> (lsr[7] || !fifo_en)); // R5
  AST_TAG_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !data_rd) |=> (lsr[4:2] == 3'b000)); // R4
  AST_THRE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && thr_wr) |=> (!lsr[5] || fifo_en)); // R7
endmodule

// File: tb/rx_line_status_tb.sv
module rx_line_status_tb;
  localparam int DEPTH = 4;
  localparam int TXW   = 3;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic data_rd = 0, lsr_rd = 0, thr_wr = 0, thr_load = 0, tsr_busy = 0;
  logic [7:0] rx_data = 0;
  logic [TXW-1:0] tx_level = 0;
  logic [7:0] rd_data, lsr;
  logic rls_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_line_status #(.DEPTH(DEPTH), .TXW(TXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_push(rx_push), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .data_rd(data_rd), .lsr_rd(lsr_rd),
    .thr_wr(thr_wr), .thr_load(thr_load), .tx_level(tx_level), .tsr_busy(tsr_busy),
    .rd_data(rd_data), .lsr(lsr), .rls_irq(rls_irq));

  // {push, data[8], tags{brk,fe,pe}[3], data_rd, lsr_rd, exp_lsr[8], exp_rd[8]}
  localparam logic [29:0] VEC [21] = '{
    {1'b1, 8'hA1, 3'b000, 1'b0, 1'b0, 8'h61, 8'hA1},
    {1'b1, 8'hB2, 3'b010, 1'b0, 1'b0, 8'hE1, 8'hA1},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE9, 8'hB2},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'hE1, 8'hB2},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE0, 8'h00},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h60, 8'h00},
    {1'b1, 8'hC3, 3'b100, 1'b0, 1'b0, 8'hF1, 8'hC3},
    {1'b1, 8'hD4, 3'b001, 1'b0, 1'b0, 8'hF1, 8'hC3},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE5, 8'hD4},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE0, 8'h00},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h60, 8'h00},
    {1'b1, 8'h11, 3'b000, 1'b0, 1'b0, 8'h61, 8'h11},
    {1'b1, 8'h22, 3'b000, 1'b0, 1'b0, 8'h61, 8'h11},
    {1'b1, 8'h33, 3'b000, 1'b0, 1'b0, 8'h61, 8'h11},
    {1'b1, 8'h44, 3'b000, 1'b0, 1'b0, 8'h61, 8'h11},
    {1'b1, 8'h55, 3'b000, 1'b0, 1'b0, 8'h63, 8'h11},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h61, 8'h11},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h61, 8'h22},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h61, 8'h33},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h61, 8'h44},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h60, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic [7:0] d, input logic [2:0] t,
                      input logic dr, input logic lr);
    @(negedge clk);
    rx_push = p; rx_data = d; {rx_brk, rx_ferr, rx_perr} = t; data_rd = dr; lsr_rd = lr;
    @(negedge clk);
    rx_push = 0; data_rd = 0; lsr_rd = 0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset lsr", lsr, 8'h60);
    chk("R10 reset irq", {7'b0, rls_irq}, 8'h00);
    rst_n = 1;

    // R1 R2 R3 R4 R5 R9: FIFO-mode vector table
    for (int i = 0; i < 21; i++) begin
      step(VEC[i][29], VEC[i][28:21], VEC[i][20:18], VEC[i][17], VEC[i][16]);
      chk($sformatf("R1-R5 vec%0d lsr", i), lsr, VEC[i][15:8]);
      chk($sformatf("R9 vec%0d irq", i), {7'b0, rls_irq}, {7'b0, |VEC[i][12:9]});
      if (VEC[i][8]) chk($sformatf("R2 vec%0d rd_data", i), rd_data, VEC[i][7:0]);
    end

    // R6 holding-empty follows transmit FIFO level
    @(negedge clk); tx_level = 3'd3; #1;
    chk("R6 level 3 lsr", lsr, 8'h00);
    tx_level = 3'd0; #1;
    chk("R6 level 0 lsr", lsr, 8'h60);
    // R8 shift register busy
    tsr_busy = 1; #1;
    chk("R8 busy lsr", lsr, 8'h20);
    tsr_busy = 0;

    // holding mode
    @(negedge clk); fifo_en = 0; #1;
    chk("R7 reset thre holding", lsr, 8'h60);
    @(negedge clk); thr_wr = 1; @(negedge clk); thr_wr = 0;
    chk("R7 thr_wr clears", lsr, 8'h00);
    @(negedge clk); thr_load = 1; @(negedge clk); thr_load = 0;
    chk("R7 thr_load sets", lsr, 8'h60);
    @(negedge clk); thr_load = 1; thr_wr = 1; @(negedge clk); thr_load = 0; thr_wr = 0;
    chk("R7 thr_wr wins", lsr, 8'h00);
    @(negedge clk); thr_load = 1; @(negedge clk); thr_load = 0;

    step(1, 8'h5A, 3'b010, 0, 0);
    chk("R5 holding no summary", lsr, 8'h69);
    step(1, 8'hA5, 3'b000, 0, 0);
    chk("R2 holding second push overruns", lsr, 8'h6B);
    chk("R9 holding irq", {7'b0, rls_irq}, 8'h01);
    chk("R2 holding keeps first", rd_data, 8'h5A);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R1 holding read empties", lsr, 8'h62);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R3 status read clears overrun", lsr, 8'h60);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule